// File: doc/BRIEF.md
# Chained PWM Start Synchronizer

This block holds up to three small PWM channels. Each channel can be started on its own, or it can be linked to the channel before it so that both leave reset on the same clock edge and keep the same counter phase. The channels are linked in the fixed order 0, 1, 2. Each channel passes a one-cycle reload marker to the next channel. A linked channel compares that marker with its own reload, and it sets a sticky error flag when the two differ. Software clears the flag by writing a one to it.

Each channel has a counter that runs in one of two modes. In the sawtooth (edge) mode it counts up only. In the triangle (center) mode it counts up and then down. The counter drives two waveform outputs. Each channel also gives an ADC trigger pulse, a reload interrupt and an input-event interrupt. The configuration registers are written through a single-cycle write strobe and cannot be read back.

Top module: `pwm_start_sync`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is 0 and no channel runs.
- R2: Writes land when `wr_en` is high, in the channel given by `wr_ch`, at the register given by `wr_addr`. Address 0 is control, 1 is the period P, 2 is compare A and 3 is compare B. The control bits are: bit0 run, bit1 follow-previous, bit2 triangle mode, bits4:3 ADC edge select, bit5 clear the error (write one), bit6 event polarity. A channel whose run bit is set starts in the cycle after the write, with its counter at 0.
- R3: A channel n>0 with follow-previous set runs in every cycle in which channel n-1 runs, including the first one. The chain is transitive.
- R4: Channel 0 ignores its follow-previous bit. With only that bit set, it stays idle.
- R5: In edge mode the counter goes 0,1,...,P and then back to 0. `pwm_a` is high while count < A and `pwm_b` is high while count < B. `sync_out` and `irq_reload` are high in the cycle where count >= P.
- R6: In triangle mode the counter goes 0 up to P, then P-1 down to 1, and then returns to 0. For P of 1 or less, it returns from P straight to 0. `pwm_a` is high while count < B, and `pwm_b` is its complement. The reload marker is high in the cycle before the return to 0.
- R7: Channels that are linked, started together and given the same period and compares produce identical waveforms and reload markers in every cycle.
- R8: In edge mode, `adc_trig` pulses for one cycle on the selected edge: 0 is the rising edge of `pwm_a`, 1 the falling edge of `pwm_a`, 2 the rising edge of `pwm_b` and 3 the falling edge of `pwm_b`.
- R9: In triangle mode, `adc_trig` pulses when the counter is rising and equals A. A value of A = 0 is treated as 1.
- R10: A running channel n>0 with follow-previous set raises `sync_err[n]` when its reload differs from `sync_out[n-1]`. The flag holds until a control write with bit5 set. If a new error and a clear happen in the same cycle, the error wins.
- R11: `irq_event` is high in the same cycle in which `evt_in` shows its active edge. With polarity 0 the active edge is rising, and with polarity 1 it is falling.
- R12: An idle channel holds its counter at 0 and drives `pwm_a`, `pwm_b`, `sync_out` and `irq_reload` low. Stopping channel n-1 also stops any channel that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel selected for the write |
| wr_addr | input | 2 | Register selected for the write |
| wr_data | input | 8 | Write data |
| evt_in | input | 3 | Input event line per channel |
| pwm_a | output | 3 | First waveform output per channel |
| pwm_b | output | 3 | Second waveform output per channel |
| sync_out | output | 3 | Reload marker passed to the next channel |
| adc_trig | output | 3 | ADC trigger pulse per channel |
| irq_reload | output | 3 | Reload interrupt request |
| irq_event | output | 3 | Input event interrupt request |
| sync_err | output | 3 | Sticky synchronization error flag |

## Verification
The bench starts a chain of three followers from a single run write. A design that let a follower begin one cycle late would show waveforms that are offset by one count from the head channel. In triangle mode the bench writes A = 0 and checks the turn points. A design without the clamp would fire its ADC trigger at the start of the period, or never. The bench links two channels with different periods and then stops them. This exposes an error flag that fails to set, or one that clears by itself once the mismatch is gone. The bench also covers channel 0 with only follow-previous set, all four ADC edge selects, and both event polarities.

// File: rtl/pwm_start_sync.sv
module pwm_start_sync #(
  parameter int NCH = 3,
  parameter int W   = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [1:0]     wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic [NCH-1:0] evt_in,
  output logic [NCH-1:0] pwm_a,
  output logic [NCH-1:0] pwm_b,
  output logic [NCH-1:0] sync_out,
  output logic [NCH-1:0] adc_trig,
  output logic [NCH-1:0] irq_reload,
  output logic [NCH-1:0] irq_event,
  output logic [NCH-1:0] sync_err
);

  logic [NCH-1:0] run_q, fol_q, ctr_q, pol_q, up_q, evt_q, pa_q, pb_q, act;
  logic [1:0]     sel_q [NCH];
  logic [W-1:0]   per_q [NCH];
  logic [W-1:0]   ca_q  [NCH];
  logic [W-1:0]   cb_q  [NCH];
  logic [W-1:0]   cnt_q [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic         wsel, rl, mism, clr, up_d;
    logic [W-1:0] cnt_d, ca_eff;

    assign wsel = wr_en && (wr_ch == CHW'(i));
    assign clr  = wsel && (wr_addr == 2'd0) && wr_data[5];

    if (i == 0) begin : g_head
      assign act[i]  = run_q[i];
      assign mism    = 1'b0;
    end else begin : g_link
      assign act[i]  = run_q[i] | (fol_q[i] & act[i-1]);
      assign mism    = fol_q[i] & act[i] & (sync_out[i-1] != rl);
    end

    always_comb begin
      if (ctr_q[i])
        rl = (up_q[i] && cnt_q[i] >= per_q[i] && per_q[i] <= W'(1)) ||
             (!up_q[i] && cnt_q[i] <= W'(1));
      else
        rl = cnt_q[i] >= per_q[i];
      cnt_d = cnt_q[i] + W'(1);
      up_d  = up_q[i];
      if (!act[i]) begin
        cnt_d = '0;
        up_d  = 1'b1;
      end else if (ctr_q[i]) begin
        if (up_q[i]) begin
          if (cnt_q[i] >= per_q[i]) begin
            if (per_q[i] <= W'(1)) begin
              cnt_d = '0;
              up_d  = 1'b1;
            end else begin
              cnt_d = per_q[i] - W'(1);
              up_d  = 1'b0;
            end
          end
        end else if (cnt_q[i] <= W'(1)) begin
          cnt_d = '0;
          up_d  = 1'b1;
        end else begin
          cnt_d = cnt_q[i] - W'(1);
        end
      end else if (cnt_q[i] >= per_q[i]) begin
        cnt_d = '0;
      end
    end

    assign ca_eff     = (ca_q[i] == '0) ? W'(1) : ca_q[i];
    assign pwm_a[i]   = act[i] & (cnt_q[i] < (ctr_q[i] ? cb_q[i] : ca_q[i]));
    assign pwm_b[i]   = act[i] & (ctr_q[i] ? (cnt_q[i] >= cb_q[i]) : (cnt_q[i] < cb_q[i]));
    assign sync_out[i]   = act[i] & rl;
    assign irq_reload[i] = act[i] & rl;
    assign irq_event[i]  = pol_q[i] ? (~evt_in[i] & evt_q[i]) : (evt_in[i] & ~evt_q[i]);

    always_comb begin
      if (ctr_q[i])
        adc_trig[i] = act[i] & up_q[i] & (cnt_q[i] == ca_eff);
      else
        case (sel_q[i])
          2'd0:    adc_trig[i] =  pwm_a[i] & ~pa_q[i];
          2'd1:    adc_trig[i] = ~pwm_a[i] &  pa_q[i];
          2'd2:    adc_trig[i] =  pwm_b[i] & ~pb_q[i];
          default: adc_trig[i] = ~pwm_b[i] &  pb_q[i];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q[i] <= 1'b0;  fol_q[i] <= 1'b0;  ctr_q[i] <= 1'b0;  pol_q[i] <= 1'b0;
        sel_q[i] <= 2'd0;  per_q[i] <= '0;    ca_q[i]  <= '0;    cb_q[i]  <= '0;
        cnt_q[i] <= '0;    up_q[i]  <= 1'b1;  sync_err[i] <= 1'b0;
        evt_q[i] <= 1'b0;  pa_q[i]  <= 1'b0;  pb_q[i]  <= 1'b0;
      end else begin
        cnt_q[i] <= cnt_d;
        up_q[i]  <= up_d;
        evt_q[i] <= evt_in[i];
        pa_q[i]  <= pwm_a[i];
        pb_q[i]  <= pwm_b[i];
        if (mism)     sync_err[i] <= 1'b1;
        else if (clr) sync_err[i] <= 1'b0;
        if (wsel)
          case (wr_addr)
            2'd0: begin
              run_q[i] <= wr_data[0];
              fol_q[i] <= wr_data[1];
              ctr_q[i] <= wr_data[2];
              sel_q[i] <= wr_data[4:3];
              pol_q[i] <= wr_data[6];
            end
            2'd1:    per_q[i] <= wr_data;
            2'd2:    ca_q[i]  <= wr_data;
            default: cb_q[i]  <= wr_data;
          endcase
      end
    end
  end

endmodule

// File: rtl/pwm_start_sync_chk.sv
module pwm_start_sync_chk #(
  parameter int NCH = 3,
  parameter int W   = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [CHW-1:0] wr_ch,
  input logic [1:0]     wr_addr,
  input logic [W-1:0]   wr_data,
  input logic [NCH-1:0] act,
  input logic [NCH-1:0] ctr_q,
  input logic [NCH-1:0] pwm_a,
  input logic [NCH-1:0] pwm_b,
  input logic [NCH-1:0] sync_out,
  input logic [NCH-1:0] adc_trig,
  input logic [NCH-1:0] irq_reload,
  input logic [NCH-1:0] irq_event,
  input logic [NCH-1:0] sync_err
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (pwm_a == '0 && pwm_b == '0 && sync_err == '0 && adc_trig == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_prop
    assert_center_complement_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_q[i] && act[i]) |-> (pwm_b[i] == !pwm_a[i]));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_err[i] && !(wr_en && wr_ch == CHW'(i) && wr_addr == 2'd0 && wr_data[5]))
      |=> sync_err[i]);

    assert_event_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_event[i] |=> !irq_event[i]);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !act[i] |-> (!pwm_a[i] && !pwm_b[i] && !sync_out[i] && !irq_reload[i]));
  end

endmodule

bind pwm_start_sync pwm_start_sync_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr),
  .wr_data(wr_data), .act(act), .ctr_q(ctr_q), .pwm_a(pwm_a), .pwm_b(pwm_b),
  .sync_out(sync_out), .adc_trig(adc_trig), .irq_reload(irq_reload),
  .irq_event(irq_event), .sync_err(sync_err)
);

// File: tb/test_pwm_start_sync.sv
`timescale 1ns/1ps
module test_pwm_start_sync;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_ch = '0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] evt_in = '0;
  logic [2:0] pwm_a, pwm_b, sync_out, adc_trig, irq_reload, irq_event, sync_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_start_sync i_pwm_start_sync (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr),
    .wr_data(wr_data), .evt_in(evt_in), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .sync_out(sync_out), .adc_trig(adc_trig), .irq_reload(irq_reload),
    .irq_event(irq_event), .sync_err(sync_err)
  );

  int m_run[3], m_fol[3], m_ctr[3], m_sel[3], m_pol[3], m_per[3], m_ca[3], m_cb[3];
  int m_cnt[3], m_up[3], m_err[3], m_evq[3], m_pa[3], m_pb[3];
  int e_act[3], e_rl[3], e_a[3], e_b[3], e_sync[3], e_adc[3], e_evt[3];

  task automatic calc();
    for (int i = 0; i < 3; i++) begin
      e_act[i] = (m_run[i] != 0 || (i > 0 && m_fol[i] != 0 && e_act[i-1] != 0)) ? 1 : 0;
      if (m_ctr[i] != 0)
        e_rl[i] = ((m_up[i] != 0 && m_cnt[i] >= m_per[i] && m_per[i] <= 1) ||
                   (m_up[i] == 0 && m_cnt[i] <= 1)) ? 1 : 0;
      else
        e_rl[i] = (m_cnt[i] >= m_per[i]) ? 1 : 0;
      if (e_act[i] == 0) begin
        e_a[i] = 0; e_b[i] = 0; e_rl[i] = 0;
      end else if (m_ctr[i] != 0) begin
        e_a[i] = (m_cnt[i] < m_cb[i]) ? 1 : 0;
        e_b[i] = 1 - e_a[i];
      end else begin
        e_a[i] = (m_cnt[i] < m_ca[i]) ? 1 : 0;
        e_b[i] = (m_cnt[i] < m_cb[i]) ? 1 : 0;
      end
      e_sync[i] = e_rl[i];
      if (m_ctr[i] != 0)
        e_adc[i] = (e_act[i] != 0 && m_up[i] != 0 && m_cnt[i] == ((m_ca[i] == 0) ? 1 : m_ca[i])) ? 1 : 0;
      else case (m_sel[i])
        0: e_adc[i] = (e_a[i] == 1 && m_pa[i] == 0) ? 1 : 0;
        1: e_adc[i] = (e_a[i] == 0 && m_pa[i] == 1) ? 1 : 0;
        2: e_adc[i] = (e_b[i] == 1 && m_pb[i] == 0) ? 1 : 0;
        default: e_adc[i] = (e_b[i] == 0 && m_pb[i] == 1) ? 1 : 0;
      endcase
      if (m_pol[i] != 0) e_evt[i] = (evt_in[i] == 1'b0 && m_evq[i] == 1) ? 1 : 0;
      else               e_evt[i] = (evt_in[i] == 1'b1 && m_evq[i] == 0) ? 1 : 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_run[i] = 0; m_fol[i] = 0; m_ctr[i] = 0; m_sel[i] = 0; m_pol[i] = 0;
        m_per[i] = 0; m_ca[i] = 0; m_cb[i] = 0; m_cnt[i] = 0; m_up[i] = 1;
        m_err[i] = 0; m_evq[i] = 0; m_pa[i] = 0; m_pb[i] = 0;
      end
    end else begin
      calc();
      for (int i = 0; i < 3; i++) begin
        if (i > 0 && m_fol[i] != 0 && e_act[i] != 0 && e_sync[i-1] != e_rl[i]) m_err[i] = 1;
        else if (wr_en && wr_ch == i && wr_addr == 0 && wr_data[5]) m_err[i] = 0;
        if (e_act[i] == 0) begin
          m_cnt[i] = 0; m_up[i] = 1;
        end else if (m_ctr[i] != 0) begin
          if (m_up[i] != 0) begin
            if (m_cnt[i] < m_per[i]) m_cnt[i]++;
            else if (m_per[i] <= 1) m_cnt[i] = 0;
            else begin m_cnt[i] = m_per[i] - 1; m_up[i] = 0; end
          end else if (m_cnt[i] <= 1) begin
            m_cnt[i] = 0; m_up[i] = 1;
          end else m_cnt[i]--;
        end else m_cnt[i] = (m_cnt[i] >= m_per[i]) ? 0 : m_cnt[i] + 1;
        m_evq[i] = evt_in[i];
        m_pa[i] = e_a[i];
        m_pb[i] = e_b[i];
        if (wr_en && wr_ch == i) case (wr_addr)
          0: begin
            m_run[i] = wr_data[0]; m_fol[i] = wr_data[1]; m_ctr[i] = wr_data[2];
            m_sel[i] = wr_data[4:3]; m_pol[i] = wr_data[6];
          end
          1: m_per[i] = wr_data;
          2: m_ca[i] = wr_data;
          default: m_cb[i] = wr_data;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act_v, exp_v, $time);
    end
  endtask

  function automatic int vec(input int v[3]);
    return (v[2] != 0 ? 4 : 0) | (v[1] != 0 ? 2 : 0) | (v[0] != 0 ? 1 : 0);
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      calc();
      chk((m_ctr[0] != 0) ? "R6" : "R5", "pwm_a", int'(pwm_a), vec(e_a));
      chk((m_ctr[0] != 0) ? "R6" : "R5", "pwm_b", int'(pwm_b), vec(e_b));
      chk("R7", "sync_out", int'(sync_out), vec(e_sync));
      chk("R5", "irq_reload", int'(irq_reload), vec(e_rl));
      chk((m_ctr[0] != 0) ? "R9" : "R8", "adc_trig", int'(adc_trig), vec(e_adc));
      chk("R11", "irq_event", int'(irq_event), vec(e_evt));
      chk("R10", "sync_err", int'(sync_err), vec(m_err));
    end
  end

  task automatic wr(input int ch, input int ad, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_addr = 2'(ad); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int ch, input int p, input int a, input int b);
    wr(ch, 1, p); wr(ch, 2, a); wr(ch, 3, b);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int pulses;
    idle(3);
    #1;
    chk("R1", "outputs in reset", int'({pwm_a, pwm_b, sync_out, adc_trig, sync_err}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1", "outputs after reset", int'({pwm_a, pwm_b, sync_out, adc_trig, irq_reload, sync_err}), 0);

    cfg(0, 5, 2, 4);
    wr(0, 0, 8'h01);
    #2;
    chk("R2", "ch0 starts high at count 0", int'(pwm_a[0]), 1);
    idle(20);

    wr(0, 0, 8'h02);
    idle(3); #2;
    chk("R4", "ch0 follow-only stays idle", int'({pwm_a[0], pwm_b[0], sync_out[0]}), 0);

    cfg(1, 5, 2, 4); cfg(2, 5, 2, 4);
    wr(1, 0, 8'h02); wr(2, 0, 8'h02);
    idle(2); #2;
    chk("R3", "followers idle before head", int'(pwm_a), 0);
    wr(0, 0, 8'h01);
    #2;
    chk("R3", "whole chain starts together", int'(pwm_a), 7);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk); #2;
      chk("R7", "linked sync_out aligned", int'(sync_out == 3'b000 || sync_out == 3'b111), 1);
      chk("R7", "linked pwm_b aligned", int'(pwm_b == 3'b000 || pwm_b == 3'b111), 1);
    end
    wr(0, 0, 8'h00);
    #2;
    chk("R12", "stopping head stops chain", int'({pwm_a, pwm_b, sync_out}), 0);
    wr(1, 0, 0); wr(2, 0, 0);

    for (int s = 1; s < 4; s++) begin
      wr(0, 0, 8'h01 | (s << 3));
      idle(14);
      wr(0, 0, 8'h00);
      idle(2);
    end

    cfg(0, 6, 0, 3); cfg(1, 6, 0, 3); cfg(2, 6, 0, 3);
    wr(1, 0, 8'h06); wr(2, 0, 8'h06);
    wr(0, 0, 8'h05);
    pulses = 0;
    for (int k = 0; k < 12; k++) begin
      #2;
      if (adc_trig[0]) pulses++;
      @(negedge clk);
    end
    chk("R9", "one clamped trigger per triangle period", pulses, 1);
    idle(4);
    wr(0, 2, 4); wr(1, 2, 4); wr(2, 2, 4);
    idle(16);
    wr(0, 0, 8'h00);
    idle(2);
    wr(1, 0, 0); wr(2, 0, 0);

    cfg(0, 5, 2, 4); cfg(1, 3, 1, 2);
    wr(1, 0, 8'h02);
    wr(0, 0, 8'h01);
    idle(12); #2;
    chk("R10", "mismatched follower flags error", int'(sync_err[1]), 1);
    wr(0, 0, 8'h00);
    idle(3); #2;
    chk("R10", "error holds after mismatch ends", int'(sync_err[1]), 1);
    wr(1, 0, 8'h20);
    #2;
    chk("R10", "write one clears error", int'(sync_err[1]), 0);

    wr(0, 0, 8'h00);
    @(negedge clk); evt_in[0] = 1'b1; #2;
    chk("R11", "rising event raises irq", int'(irq_event[0]), 1);
    @(negedge clk); #2;
    chk("R11", "event irq is one cycle", int'(irq_event[0]), 0);
    @(negedge clk); evt_in[0] = 1'b0;
    wr(0, 0, 8'h40);
    @(negedge clk); evt_in[0] = 1'b1;
    @(negedge clk); evt_in[0] = 1'b0; #2;
    chk("R11", "falling event with polarity 1", int'(irq_event[0]), 1);
    idle(3);
    finish_run();
  end
endmodule